// File: doc/BRIEF.md
# Compare Event Trigger Path

This block takes two comparator-derived trip events belonging to one PWM channel and turns each of them into the signals the rest of the channel consumes. For every event it picks either the raw compare event or an already filtered copy of it. It then forwards that choice to the trip logic, either unchanged or after a short synchronizer on the time-base clock. Each event also sets a sticky flag that software can clear. The flag, ANDed with an enable, forms an interrupt request.

The first event has two further outputs. Each is a one-cycle pulse on the rising edge of the selected event, and each has its own enable. One requests an ADC start-of-conversion and the other resynchronizes the time-base counter. Register-style inputs supply the selects, the enables, a software force strobe and a software clear strobe per event. The filtering logic, the comparators and the PWM action logic lie outside this block.

Bit 0 of every per-event vector belongs to event 1 and bit 1 belongs to event 2.

Top module: `cmp_trig_path`

## Requirements
- R1: For each event, `srcSel[e]`=0 selects `rawEvt[e]` and `srcSel[e]`=1 selects `filtEvt[e]`. The input that is not selected has no effect on any output.
- R2: With `asyncSel[e]`=1 the selected event drives `evtForce[e]` combinationally, in the same cycle and with no register on the way.
- R3: With `asyncSel[e]`=0 the selected event passes through a chain of `SYNC_STAGES` flops on `clk`. It reaches `evtForce[e]` `SYNC_STAGES` rising edges after it is applied. The flag and the pulses follow that delayed level.
- R4: On a rising edge of `clk`, `evtFlag[e]` becomes 1 when the path level or `swForce[e]` is 1 before that edge.
- R5: A `swClear[e]` pulse clears `evtFlag[e]` at the next edge. When set and clear occur in the same cycle, the flag is set.
- R6: `intReq[e]` is 1 exactly when `evtFlag[e]` and `intEn[e]` are both 1.
- R7: `socPulse` is high for one cycle, one edge after a 0-to-1 transition of event 1's path level, and only when `socEn` is 1 in that cycle. `swForce` does not produce it.
- R8: `cntSyncPulse` follows the same rule as R7, gated by `syncEn` instead of `socEn`.
- R9: `swForce[e]` asserts `evtForce[e]` in the cycle it is high, whichever path is selected.
- R10: While `rstN` is low, both flags, both synchronizer chains and both pulses are 0. The asynchronous path stays combinational.
- R11: Event 2 never produces `socPulse` or `cntSyncPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rawEvt | input | 2 | Raw compare events |
| filtEvt | input | 2 | Filtered compare events |
| srcSel | input | 2 | Source choice per event, 1 = filtered |
| asyncSel | input | 2 | Path choice per event, 1 = bypass synchronizer |
| swForce | input | 2 | Software force strobes |
| swClear | input | 2 | Software flag clear strobes |
| intEn | input | 2 | Interrupt enables |
| socEn | input | 1 | Start-of-conversion enable, event 1 |
| syncEn | input | 1 | Counter-sync enable, event 1 |
| evtForce | output | 2 | Force level toward the trip logic |
| evtFlag | output | 2 | Latched event flags |
| intReq | output | 2 | Interrupt requests |
| socPulse | output | 1 | Start-of-conversion pulse |
| cntSyncPulse | output | 1 | Counter-sync pulse |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. At that depth, the directed test can count the edges after which a held event appears on the force output, then on the flag, then on the sync pulse. With the event count fixed at two, the table can drive one event on the synchronized path and the other on the bypass path at the same time. It can also pit set against clear on one flag while the other flag holds its value.

// File: rtl/cmp_trig_pkg.sv
package cmp_trig_pkg;
  localparam int NUM_EVT = 2;
  localparam int PRIM_EVT = 0;

  // strobes passed from control to datapath
  typedef struct packed {
    logic [NUM_EVT-1:0] forceLvl;  // path level OR software force
    logic [NUM_EVT-1:0] clrReq;    // software clear
    logic               primRise;  // rising edge of event 1 path level
  } ctrlStrobe_t;
endpackage

// File: rtl/cmp_trig_ctrl.sv
module cmp_trig_ctrl
  import cmp_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] rawEvt,
  input  logic [NUM_EVT-1:0] filtEvt,
  input  logic [NUM_EVT-1:0] srcSel,
  input  logic [NUM_EVT-1:0] asyncSel,
  input  logic [NUM_EVT-1:0] swForce,
  input  logic [NUM_EVT-1:0] swClear,
  output ctrlStrobe_t        strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_EVT-1:0] pathLvl;
  logic               primPrev;

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    logic                   chosen;
    logic [SYNC_STAGES-1:0] chain;

    assign chosen = srcSel[e] ? filtEvt[e] : rawEvt[e];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[LAST-1:0], chosen};
    end

    assign pathLvl[e] = asyncSel[e] ? chosen : chain[LAST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primPrev <= 1'b0;
    else       primPrev <= pathLvl[PRIM_EVT];
  end

  always_comb begin
    strobe.forceLvl = pathLvl | swForce;
    strobe.clrReq   = swClear;
    strobe.primRise = pathLvl[PRIM_EVT] & ~primPrev;
  end
endmodule

// File: rtl/cmp_trig_dpath.sv
module cmp_trig_dpath
  import cmp_trig_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_EVT-1:0] intEn,
  input  logic               socEn,
  input  logic               syncEn,
  output logic [NUM_EVT-1:0] evtForce,
  output logic [NUM_EVT-1:0] evtFlag,
  output logic [NUM_EVT-1:0] intReq,
  output logic               socPulse,
  output logic               cntSyncPulse
);
  for (genvar e = 0; e < NUM_EVT; e++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    evtFlag[e] <= 1'b0;
      else if (strobe.forceLvl[e])  evtFlag[e] <= 1'b1;  // set wins
      else if (strobe.clrReq[e])    evtFlag[e] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      socPulse     <= 1'b0;
      cntSyncPulse <= 1'b0;
    end else begin
      socPulse     <= strobe.primRise & socEn;
      cntSyncPulse <= strobe.primRise & syncEn;
    end
  end

  assign evtForce = strobe.forceLvl;
  assign intReq   = evtFlag & intEn;
endmodule

// File: rtl/cmp_trig_path.sv
module cmp_trig_path
  import cmp_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] rawEvt,
  input  logic [NUM_EVT-1:0] filtEvt,
  input  logic [NUM_EVT-1:0] srcSel,
  input  logic [NUM_EVT-1:0] asyncSel,
  input  logic [NUM_EVT-1:0] swForce,
  input  logic [NUM_EVT-1:0] swClear,
  input  logic [NUM_EVT-1:0] intEn,
  input  logic               socEn,
  input  logic               syncEn,
  output logic [NUM_EVT-1:0] evtForce,
  output logic [NUM_EVT-1:0] evtFlag,
  output logic [NUM_EVT-1:0] intReq,
  output logic               socPulse,
  output logic               cntSyncPulse
);
  ctrlStrobe_t strobe;

  cmp_trig_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rawEvt(rawEvt), .filtEvt(filtEvt),
    .srcSel(srcSel), .asyncSel(asyncSel), .swForce(swForce),
    .swClear(swClear), .strobe(strobe)
  );

  cmp_trig_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intEn(intEn),
    .socEn(socEn), .syncEn(syncEn), .evtForce(evtForce),
    .evtFlag(evtFlag), .intReq(intReq), .socPulse(socPulse),
    .cntSyncPulse(cntSyncPulse)
  );
endmodule

// File: rtl/cmp_trig_chk.sv
module cmp_trig_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] swClear,
  input logic       socEn,
  input logic       syncEn,
  input logic [1:0] evtForce,
  input logic [1:0] evtFlag,
  input logic       socPulse,
  input logic       cntSyncPulse
);
  p_flag_set0_r4: assert property (@(posedge clk) disable iff (!rstN)
    evtForce[0] |=> evtFlag[0]);
  p_flag_set1_r4: assert property (@(posedge clk) disable iff (!rstN)
    evtForce[1] |=> evtFlag[1]);
  p_flag_clr0_r5: assert property (@(posedge clk) disable iff (!rstN)
    (swClear[0] && !evtForce[0]) |=> !evtFlag[0]);
  p_flag_clr1_r5: assert property (@(posedge clk) disable iff (!rstN)
    (swClear[1] && !evtForce[1]) |=> !evtFlag[1]);
  p_flag_hold0_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!evtForce[0] && !swClear[0]) |=> $stable(evtFlag[0]));
  p_soc_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    socPulse |=> !socPulse);
  p_soc_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    socPulse |-> $past(socEn));
  p_sync_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    cntSyncPulse |=> !cntSyncPulse);
  p_sync_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    cntSyncPulse |-> $past(syncEn));
endmodule

bind cmp_trig_path cmp_trig_chk u_chk (
  .clk(clk), .rstN(rstN), .swClear(swClear), .socEn(socEn),
  .syncEn(syncEn), .evtForce(evtForce), .evtFlag(evtFlag),
  .socPulse(socPulse), .cntSyncPulse(cntSyncPulse)
);

// File: tb/tb_cmp_trig_path.sv
module tb_cmp_trig_path;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] rawEvt = '0, filtEvt = '0, srcSel = '0, asyncSel = '0;
  logic [1:0] swForce = '0, swClear = '0, intEn = '0;
  logic socEn = 1'b0, syncEn = 1'b0;
  logic [1:0] evtForce, evtFlag, intReq;
  logic socPulse, cntSyncPulse;
  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;  // 50 MHz

  cmp_trig_path dut (.*);

  // fields: raw filt src frc clr ien soc syn | eForce eFlag eInt eSoc eSyn
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    22'b00_00_00_00_00_00_0_0_00_00_00_0_0,  // idle
    22'b01_00_00_00_00_11_1_1_01_01_01_1_1,  // R2 R7 R8 rise of event 1
    22'b01_00_00_00_00_11_1_1_01_01_01_0_0,  // R7 R8 held level, no pulse
    22'b00_11_00_00_01_11_0_0_00_00_00_0_0,  // R1 filtered ignored, R5 clear
    22'b00_10_10_00_00_01_1_1_10_10_00_0_0,  // R1 filtered ev2, R11, R6 gate
    22'b00_00_00_01_00_01_1_0_01_11_01_0_0,  // R9 sw force sets, no SOC
    22'b00_00_00_00_11_11_0_0_00_00_00_0_0,  // R5 clear both
    22'b10_00_00_00_10_10_0_0_10_10_10_0_0,  // R5 set wins over clear
    22'b01_00_00_00_00_00_0_1_01_11_00_0_1,  // R7 gated off, R8 on
    22'b00_00_00_00_11_00_0_0_00_00_00_0_0,
    22'b00_01_01_00_00_00_1_0_01_01_00_1_0   // R1 filtered ev1 rise
  };

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chkAll(input string tag, input logic [1:0] eF, input logic [1:0] eG,
                        input logic [1:0] eI, input logic eS, input logic eY);
    chk({tag, " R2/R9 evtForce"}, evtForce, eF);
    chk({tag, " R4/R5 evtFlag"}, evtFlag, eG);
    chk({tag, " R6 intReq"}, intReq, eI);
    chk({tag, " R7 socPulse"}, {1'b0, socPulse}, {1'b0, eS});
    chk({tag, " R8 cntSyncPulse"}, {1'b0, cntSyncPulse}, {1'b0, eY});
  endtask

  initial begin
    #(200000 * 20);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chkAll("R10 reset", 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
    asyncSel = 2'b11;
    rstN = 1'b1;
    for (int k = 0; k < NV; k++) begin
      logic [21:0] v;
      v = VEC[k];
      {rawEvt, filtEvt, srcSel, swForce, swClear, intEn, socEn, syncEn} = v[21:8];
      @(negedge clk);
      chkAll($sformatf("vec%0d", k), v[7:6], v[5:4], v[3:2], v[1], v[0]);
    end

    // R10 reset mid-run, async path stays combinational
    {filtEvt, srcSel, swForce, swClear, intEn, socEn, syncEn} = '0;
    rawEvt = 2'b01; asyncSel = 2'b01; rstN = 1'b0;
    @(negedge clk);
    chkAll("R10 midrun", 2'b01, 2'b00, 2'b00, 1'b0, 1'b0);
    rawEvt = 2'b00; rstN = 1'b1;
    @(negedge clk);

    // R3 synchronized event 1 alongside bypassed event 2
    asyncSel = 2'b10; rawEvt = 2'b11; syncEn = 1'b1; intEn = 2'b11;
    @(negedge clk);
    chkAll("R3 edge1", 2'b10, 2'b10, 2'b10, 1'b0, 1'b0);
    @(negedge clk);
    chkAll("R3 edge2", 2'b11, 2'b10, 2'b10, 1'b0, 1'b0);
    @(negedge clk);
    chkAll("R3 edge3", 2'b11, 2'b11, 2'b11, 1'b0, 1'b1);
    @(negedge clk);
    chkAll("R3 edge4", 2'b11, 2'b11, 2'b11, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule